// File: doc/BRIEF.md
# Parallel PRBS Error Counter

This block compares a parallel receive data stream, one word per clock, against a pseudo-random binary sequence. The polynomial is not fixed. A tap mask supplied at run time selects it, so one instance can check several sequence lengths. The checker synchronizes itself: it predicts each received bit from bits received earlier, so it needs no seed and no alignment step. A few words after the sequence starts, a clean link produces no mismatches.

A two-bit source select picks the input word. The choices are the data converter output, the equalizer output, or the built-in self-test pattern. A two-bit mode code controls the counters: clear, accumulate, or freeze for readout. There are two saturating counters, one for bits checked and one for bits in error. Each counter appears on the ports as separate upper and lower halves, so a narrow register path can read it one word at a time.

Top module: `prbs_monitor`

## Requirements
- R1: While rst_ni is low, all four count outputs are zero, and the bit history behind the prediction is cleared to zeros.
- R2: Bit k of poly_mask_i set means a tap at the bit received k+1 positions earlier. With mask 0x100002 (taps 21 and 2) on a PRBS21 stream, or mask 0x60 (taps 7 and 6) on a PRBS7 stream, the error count stays zero after three warm-up words.
- R3: The predicted bit is the XOR of the received bits at the tapped delays. An error is a predicted bit that differs from the received bit. One flipped bit under mask 0x100002 therefore gives exactly 3 errors.
- R4: Within each word, bit 0 is the earliest bit. A word sampled at clock edge n is counted at edge n+1 if mode_i equals 2 at that edge. The total count rises by LANES and the error count rises by the number of mismatched bits.
- R5: With mode_i equal to 3, both counts hold their values regardless of the data.
- R6: With mode_i equal to 0 or 1, both counts are zero after the next edge.
- R7: src_sel_i chooses the checked word: 0 is conv_data_i, 1 is eq_data_i, 3 is bist_data_i, and 2 feeds an all-zero word. The unselected inputs have no effect on the counts.
- R8: Each count stops at its all-ones value and never wraps.
- R9: The upper half output carries count bits [CNT_W-1:CNT_W/2] and the lower half carries bits [CNT_W/2-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_data_i | input | LANES | Data converter word |
| eq_data_i | input | LANES | Equalizer word |
| bist_data_i | input | LANES | Self-test pattern word |
| src_sel_i | input | 2 | Source select |
| poly_mask_i | input | POLY_W | Polynomial tap mask |
| mode_i | input | 2 | Counter mode code |
| err_hi_o | output | CNT_W/2 | Error count, upper half |
| err_lo_o | output | CNT_W/2 | Error count, lower half |
| tot_hi_o | output | CNT_W/2 | Total count, upper half |
| tot_lo_o | output | CNT_W/2 | Total count, lower half |

## Verification
A word is latched by the source register at the first edge after it is driven. Its mismatches reach the counters at the second edge, under the mode value present at that edge. The bench therefore drives a word and a mode together at each falling edge. Its serial reference model credits the statistics of the word driven one step earlier to the mode driven now. It reads the counts at the falling edge after the update. A second instance with 8-bit counters receives the same stimulus, so saturation and the half split are checked against the same model, clipped at 255.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  typedef enum logic [1:0] {
    MODE_CLR_A = 2'd0,
    MODE_CLR_B = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_HOLD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_CONV = 2'd0,
    SRC_EQ   = 2'd1,
    SRC_NONE = 2'd2,
    SRC_BIST = 2'd3
  } src_e;
endpackage

// File: rtl/prbs_src_mux.sv
module prbs_src_mux
  import prbs_mon_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic [LANES-1:0] conv_i,
  input  logic [LANES-1:0] eq_i,
  input  logic [LANES-1:0] bist_i,
  output logic [LANES-1:0] word_o
);
  logic [LANES-1:0] pick;

  always_comb begin
    unique case (src_e'(sel_i))
      SRC_CONV: pick = conv_i;
      SRC_EQ:   pick = eq_i;
      SRC_BIST: pick = bist_i;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= pick;
  end
endmodule

// File: rtl/prbs_lane_check.sv
module prbs_lane_check #(
  parameter int LANES  = 16,
  parameter int POLY_W = 32,
  parameter int ERR_W  = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  word_i,
  input  logic [POLY_W-1:0] mask_i,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int EXT_W = POLY_W + LANES;

  logic [POLY_W-1:0] hist_q;
  logic [EXT_W-1:0]  ext;
  logic [LANES-1:0]  miss;

  // ext[POLY_W-1] is the newest history bit, ext[POLY_W] the oldest new bit
  assign ext = {word_i, hist_q};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic pred;
    always_comb begin
      pred = 1'b0;
      for (int k = 0; k < POLY_W; k++) begin
        if (mask_i[k]) pred = pred ^ ext[POLY_W + j - (k + 1)];
      end
    end
    assign miss[j] = pred ^ ext[POLY_W + j];
  end

  always_comb begin
    err_cnt_o = '0;
    for (int j = 0; j < LANES; j++) err_cnt_o = err_cnt_o + ERR_W'(miss[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= ext[EXT_W-1 -: POLY_W];
  end
endmodule

// File: rtl/prbs_sat_cnt.sv
module prbs_sat_cnt #(
  parameter int CNT_W = 64,
  parameter int INC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + (CNT_W + 1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/prbs_monitor.sv
module prbs_monitor
  import prbs_mon_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int POLY_W = 32,
  parameter int CNT_W  = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  conv_data_i,
  input  logic [LANES-1:0]  eq_data_i,
  input  logic [LANES-1:0]  bist_data_i,
  input  logic [1:0]        src_sel_i,
  input  logic [POLY_W-1:0] poly_mask_i,
  input  logic [1:0]        mode_i,
  output logic [HALF_W-1:0] err_hi_o,
  output logic [HALF_W-1:0] err_lo_o,
  output logic [HALF_W-1:0] tot_hi_o,
  output logic [HALF_W-1:0] tot_lo_o
);
  localparam int INC_W = $clog2(LANES + 1);

  logic [LANES-1:0] word_q;
  logic [INC_W-1:0] err_inc;
  logic [CNT_W-1:0] err_cnt, tot_cnt;
  logic             run, clr;

  assign run = mode_e'(mode_i) == MODE_RUN;
  assign clr = !mode_i[1];

  prbs_src_mux #(.LANES(LANES)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (src_sel_i),
    .conv_i (conv_data_i),
    .eq_i   (eq_data_i),
    .bist_i (bist_data_i),
    .word_o (word_q)
  );

  prbs_lane_check #(.LANES(LANES), .POLY_W(POLY_W), .ERR_W(INC_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (word_q),
    .mask_i    (poly_mask_i),
    .err_cnt_o (err_inc)
  );

  prbs_sat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_err_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (run),
    .inc_i  (err_inc),
    .cnt_o  (err_cnt)
  );

  prbs_sat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_tot_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (run),
    .inc_i  (INC_W'(LANES)),
    .cnt_o  (tot_cnt)
  );

  assign err_hi_o = err_cnt[CNT_W-1 -: HALF_W];
  assign err_lo_o = err_cnt[HALF_W-1:0];
  assign tot_hi_o = tot_cnt[CNT_W-1 -: HALF_W];
  assign tot_lo_o = tot_cnt[HALF_W-1:0];
endmodule

// File: rtl/prbs_monitor_sva.sv
module prbs_monitor_sva #(
  parameter int LANES  = 16,
  parameter int CNT_W  = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [HALF_W-1:0] err_hi_o,
  input logic [HALF_W-1:0] err_lo_o,
  input logic [HALF_W-1:0] tot_hi_o,
  input logic [HALF_W-1:0] tot_lo_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] STEP = CNT_W'(LANES);

  logic [CNT_W-1:0] err, tot;
  assign err = {err_hi_o, err_lo_o};
  assign tot = {tot_hi_o, tot_lo_o};

  AST_RUN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && tot <= MAXV - STEP) |=> tot == $past(tot) + STEP); // R4
  AST_ERR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err <= tot); // R4
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd3 |=> $stable(tot) && $stable(err)); // R5
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |=> tot == '0 && err == '0); // R6
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |=> tot >= $past(tot) && err >= $past(err)); // R8
endmodule

bind prbs_monitor prbs_monitor_sva #(.LANES(LANES), .CNT_W(CNT_W)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .err_hi_o (err_hi_o),
  .err_lo_o (err_lo_o),
  .tot_hi_o (tot_hi_o),
  .tot_lo_o (tot_lo_o)
);

// File: tb/prbs_monitor_bench.sv
module prbs_monitor_bench;
  localparam int L = 16;
  localparam logic [31:0] M21 = 32'h0010_0002;
  localparam logic [31:0] M7  = 32'h0000_0060;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] conv = '0, eq = '0, bist = '0;
  logic [1:0]  sel = 2'd0, mode = 2'd0;
  logic [31:0] mask = M21;
  logic [31:0] e_hi, e_lo, t_hi, t_lo;
  logic [3:0]  se_hi, se_lo, st_hi, st_lo;

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] g_hist = 64'h1;   // generator history
  logic [63:0] m_hist = '0;      // model history
  longint unsigned exp_err = 0, exp_tot = 0;
  int prev_err = 0;

  always #5 clk = ~clk;

  prbs_monitor u_prbs_monitor (
    .clk_i(clk), .rst_ni(rst_n), .conv_data_i(conv), .eq_data_i(eq),
    .bist_data_i(bist), .src_sel_i(sel), .poly_mask_i(mask), .mode_i(mode),
    .err_hi_o(e_hi), .err_lo_o(e_lo), .tot_hi_o(t_hi), .tot_lo_o(t_lo)
  );

  prbs_monitor #(.CNT_W(8)) u_prbs_monitor_sat (
    .clk_i(clk), .rst_ni(rst_n), .conv_data_i(conv), .eq_data_i(eq),
    .bist_data_i(bist), .src_sel_i(sel), .poly_mask_i(mask), .mode_i(mode),
    .err_hi_o(se_hi), .err_lo_o(se_lo), .tot_hi_o(st_hi), .tot_lo_o(st_lo)
  );

  task automatic chk(string req, string what, longint unsigned got, longint unsigned expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, expv);
    end
  endtask

  function automatic longint unsigned clip(longint unsigned v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic chk_counts(string req);
    chk(req, "err", {e_hi, e_lo}, exp_err);
    chk(req, "tot", {t_hi, t_lo}, exp_tot);
    chk(req, "sat err", {se_hi, se_lo}, clip(exp_err));
    chk(req, "sat tot", {st_hi, st_lo}, clip(exp_tot));
  endtask

  task automatic gen_word(output logic [L-1:0] w);
    for (int j = 0; j < L; j++) begin
      logic b;
      b = ^(mask & g_hist[31:0]);
      w[j] = b;
      g_hist = {g_hist[62:0], b};
    end
  endtask

  // serial reference: each bit predicted from earlier bits
  task automatic model_word(input logic [L-1:0] w, output int e);
    e = 0;
    for (int j = 0; j < L; j++) begin
      logic p;
      p = ^(mask & m_hist[31:0]);
      if (p != w[j]) e++;
      m_hist = {m_hist[62:0], w[j]};
    end
  endtask

  task automatic step(input logic [L-1:0] w, input logic [1:0] m);
    logic [L-1:0] eff;
    int e;
    conv = L'($urandom); eq = L'($urandom); bist = L'($urandom);
    case (sel)
      2'd0: conv = w;
      2'd1: eq = w;
      2'd3: bist = w;
      default: ;
    endcase
    eff = (sel == 2'd2) ? '0 : w;
    mode = m;
    if (m == 2'd2) begin
      exp_tot += L;
      exp_err += longint'(prev_err);
    end else if (!m[1]) begin
      exp_tot = 0;
      exp_err = 0;
    end
    model_word(eff, e);
    prev_err = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_clean(input int n, input logic [1:0] m);
    logic [L-1:0] w;
    for (int i = 0; i < n; i++) begin
      gen_word(w);
      step(w, m);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mode = 2'd0;
    repeat (2) @(negedge clk);
    m_hist = '0; prev_err = 0; exp_err = 0; exp_tot = 0;
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "err_hi at reset", e_hi, 0);
    chk("R1", "err_lo at reset", e_lo, 0);
    chk("R1", "tot_hi at reset", t_hi, 0);
    chk("R1", "tot_lo at reset", t_lo, 0);
    do_reset();
    run_clean(3, 2'd0);
    run_clean(6, 2'd2);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "tot during mid-run reset", {t_hi, t_lo}, 0);
    do_reset();
    chk_counts("R1");
  endtask

  task automatic t_clean21();
    mask = M21; sel = 2'd1;
    run_clean(3, 2'd0);
    run_clean(40, 2'd2);
    chk("R2", "prbs21 err", {e_hi, e_lo}, 0);
    chk("R4", "prbs21 tot", {t_hi, t_lo}, 40 * L);
    chk_counts("R4");
  endtask

  task automatic t_clean7();
    mask = M7; sel = 2'd1;
    run_clean(3, 2'd0);
    run_clean(30, 2'd2);
    chk("R2", "prbs7 err", {e_hi, e_lo}, 0);
    chk_counts("R2");
    mask = M21;
  endtask

  task automatic t_flip();
    logic [L-1:0] w;
    mask = M21; sel = 2'd1;
    run_clean(3, 2'd0);
    run_clean(5, 2'd2);
    gen_word(w);
    step(w ^ L'(1 << 5), 2'd2);
    run_clean(5, 2'd2);
    run_clean(1, 2'd3);
    chk("R3", "single flip err", {e_hi, e_lo}, 3);
    chk_counts("R3");
  endtask

  task automatic t_hold();
    longint unsigned se, st;
    mask = M21; sel = 2'd1;
    run_clean(3, 2'd0);
    for (int i = 0; i < 4; i++) step(L'($urandom), 2'd2);
    run_clean(1, 2'd3);
    se = {e_hi, e_lo}; st = {t_hi, t_lo};
    for (int i = 0; i < 5; i++) step(L'($urandom), 2'd3);
    chk("R5", "held err", {e_hi, e_lo}, se);
    chk("R5", "held tot", {t_hi, t_lo}, st);
    chk_counts("R5");
  endtask

  task automatic t_clear();
    run_clean(4, 2'd2);
    run_clean(1, 2'd1);
    chk("R6", "tot after mode 1", {t_hi, t_lo}, 0);
    chk_counts("R6");
    run_clean(4, 2'd2);
    run_clean(1, 2'd0);
    chk("R6", "tot after mode 0", {t_hi, t_lo}, 0);
    chk("R6", "err after mode 0", {e_hi, e_lo}, 0);
  endtask

  task automatic t_sources();
    logic [1:0] codes [4] = '{2'd0, 2'd1, 2'd3, 2'd2};
    foreach (codes[i]) begin
      sel = codes[i];
      mask = M21;
      run_clean(3, 2'd0);
      run_clean(8, 2'd2);
      chk("R7", $sformatf("err with select %0d", codes[i]), {e_hi, e_lo}, 0);
      chk_counts("R7");
    end
    sel = 2'd1;
  endtask

  task automatic t_sat_halves();
    sel = 2'd1; mask = M21;
    run_clean(3, 2'd0);
    run_clean(5, 2'd2);
    chk("R9", "sat tot upper half", st_hi, 4'h5);
    chk("R9", "sat tot lower half", st_lo, 4'h0);
    chk("R9", "main tot upper half", t_hi, 0);
    chk("R9", "main tot lower half", t_lo, 80);
    run_clean(20, 2'd2);
    chk("R8", "sat tot stuck", {st_hi, st_lo}, 255);
    chk("R8", "main tot", {t_hi, t_lo}, 25 * L);
    for (int i = 0; i < 20; i++) step({L{1'b1}}, 2'd2);
    chk("R8", "sat err stuck", {se_hi, se_lo}, 255);
    chk_counts("R8");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog req=all actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean21();
    t_clean7();
    t_flip();
    t_hold();
    t_clear();
    t_sources();
    t_sat_halves();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule